// File: doc/BRIEF.md
# Dual-Buffer Frame Receive Unit

This unit takes complete frames from the receive side of a MAC, one byte per cycle. A start marker opens each frame and an end marker closes it. Each accepted frame is stored in one of two on-chip buffers, called ping and pong. Once the last byte is stored, the unit sets that buffer's done flag. Software then reads the stored words over a 32-bit register port. It releases the buffer by clearing the done flag.

Frames go to ping first and then alternate between the two buffers, so software reads them in the same alternating order. A buffer stays reserved while its done flag is set. A frame aimed at a reserved buffer is thrown away whole, and the alternation does not move on.

A build parameter removes the pong buffer. Every frame then lands in ping. Each buffer has its own interrupt enable, and the unit raises a one-cycle interrupt pulse whenever a frame completes in a buffer whose enable is set.

Top module: `rxpp_dual_rx`

## Requirements
- R1: After reset, both done flags and both interrupt enables are 0, `rx_irq` is low, and the first frame is stored in ping.
- R2: Byte address map: ping data words start at 0x1000 and the ping status word is at 0x17FC. Pong data words start at 0x1800 and the pong status word is at 0x1FFC. In a status word, bit 0 is done and bit 3 is interrupt enable. Every other address reads as zero.
- R3: Frame byte k is stored in data word k/4, in byte lane k mod 4, with lane 0 in bits 7:0. Unused lanes of the final word read as zero.
- R4: The done flag of the receiving buffer reads 1 from the cycle after the cycle that accepts the end-marked byte.
- R5: With the pong buffer enabled, stored frames alternate ping, pong, ping, and so on.
- R6: A frame whose target buffer has done set is discarded completely. The buffer's contents stay unchanged, and the next frame aims at the same buffer.
- R7: A write to a status word sets the interrupt enable to bit 3 of the written data and ANDs done with bit 0. Software can therefore only clear done. Writing 0x8 frees the buffer and enables its interrupt.
- R8: `rx_irq` is high for exactly one cycle, the same cycle in which done first reads 1, and only if that buffer's interrupt enable is set.
- R9: Buffer capacity is 511 words (2044 bytes). Bytes beyond that are dropped, the status word is not overwritten, and the frame still completes.
- R10: With `PONG_EN` = 0, every frame goes to ping, and the pong data and status addresses read zero.
- R11: Bytes that arrive outside an open frame are ignored. A start marker in the middle of a frame restarts storage at word 0 of the same buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_eof | input | 1 | This byte is the last byte of a frame |
| bus_addr | input | ADDR_W | Byte address for register reads and writes |
| bus_wr | input | 1 | Write strobe; only status words accept writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rx_irq | output | 1 | One-cycle pulse when a frame completes in a buffer with interrupt enabled |

## Verification
The assertions check the following properties on every cycle:
- No data word is ever written into a buffer whose done flag is set.
- The word index never reaches the status slot.
- A done flag rises only after a frame completes, and it is always set after a completion.
- Every interrupt pulse matches a rising done flag whose enable was set.

Only the bench scenarios can show byte-lane packing, the order in which the buffers alternate, and the drop-and-retry behaviour with its contents kept intact. The same holds for truncation at the buffer end, the restart on a second start marker, and the single-buffer build.

// File: rtl/rxpp_pkg.sv
// Package: shared constants and types for the dual-buffer receive unit.
// Assumes status bit positions are fixed by the software contract.
package rxpp_pkg;
    localparam int DONE_BIT = 0;
    localparam int IE_BIT   = 3;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_STORE = 2'd1,
        WR_DROP  = 2'd2
    } wr_state_t;
endpackage

// File: rtl/rxpp_frame_writer.sv
// Module: frame writer. Packs the incoming bytes into words, least significant
// byte first, and picks the target buffer. A frame whose target buffer is held
// is dropped. A completed frame is committed and the pointer alternates.
// Assumes at most one byte per cycle and that buf_done only falls through software.
module rxpp_frame_writer
    import rxpp_pkg::*;
#(
    parameter int IDX_W     = 9,
    parameter int BUF_WORDS = 511,
    parameter bit PONG_EN   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [1:0]         buf_done,
    output logic               wr_en,
    output logic               wr_sel,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [WORD_W-1:0]  wr_word,
    output logic               commit
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(BUF_WORDS);

    wr_state_t          state;
    logic               tgt;
    logic [IDX_W-1:0]   idx;
    logic [1:0]         lane;
    logic [WORD_W-1:0]  acc;

    logic               start, storing, word_full;
    logic [1:0]         lane_eff;
    logic [IDX_W-1:0]   idx_eff;
    logic [WORD_W-1:0]  byte_acc;

    // Work out the word in progress, including the byte on the input this cycle.
    always_comb begin
        start     = in_valid && in_sof && !buf_done[tgt];
        storing   = start || (in_valid && !in_sof && state == WR_STORE);
        lane_eff  = start ? 2'd0 : lane;
        idx_eff   = start ? '0 : idx;
        byte_acc  = (start ? '0 : acc) | (WORD_W'(in_data) << {lane_eff, 3'b000});
        word_full = (lane_eff == 2'd3);
        wr_en     = storing && (word_full || in_eof) && (idx_eff < LIMIT);
        wr_sel    = tgt;
        wr_idx    = idx_eff;
        wr_word   = byte_acc;
        commit    = storing && in_eof;
    end

    // Frame sequencing: store, drop, commit and buffer alternation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_IDLE;
            tgt   <= 1'b0;
            idx   <= '0;
            lane  <= '0;
            acc   <= '0;
        end else if (in_valid) begin
            if (in_sof && buf_done[tgt]) begin
                state <= in_eof ? WR_IDLE : WR_DROP;
            end else if (storing) begin
                lane <= lane_eff + 2'd1;
                acc  <= word_full ? '0 : byte_acc;
                idx  <= (word_full && idx_eff < LIMIT) ? idx_eff + 1'b1 : idx_eff;
                if (in_eof) begin
                    state <= WR_IDLE;
                    tgt   <= PONG_EN ? ~tgt : 1'b0;
                end else begin
                    state <= WR_STORE;
                end
            end else if (in_eof) begin
                state <= WR_IDLE;
            end
        end
    end

    // R6: no word ever lands in a buffer that software still holds
    a_r6_no_store_into_held: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !buf_done[wr_sel]);
    // R9: the write index never reaches the status slot
    a_r9_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < LIMIT));
endmodule

// File: rtl/rxpp_buffer.sv
// Module: one frame buffer. Holds the word storage and the done and interrupt
// enable bits. Assumes a commit never targets a buffer whose done is set.
module rxpp_buffer
    import rxpp_pkg::*;
#(
    parameter int IDX_W     = 9,
    parameter int BUF_WORDS = 511
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic               commit,
    input  logic               sw_wr,
    input  logic               sw_done_keep,
    input  logic               sw_ie,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_word,
    output logic               done,
    output logic               ie
);
    logic [WORD_W-1:0] mem [BUF_WORDS];

    // Word storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_word;
    end

    // Read port; indices past the storage return zero.
    always_comb begin
        rd_word = (rd_idx < IDX_W'(BUF_WORDS)) ? mem[rd_idx] : '0;
    end

    // Status bits: hardware sets done, software may only clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            ie   <= 1'b0;
        end else begin
            if (sw_wr) ie <= sw_ie;
            if (commit)     done <= 1'b1;
            else if (sw_wr) done <= done & sw_done_keep;
        end
    end

    // R4: a completed frame always leaves done set
    a_r4_commit_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> done);
    // R7: software can never be the source of a rising done
    a_r7_done_rises_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(commit));
endmodule

// File: rtl/rxpp_dual_rx.sv
// Module: top of the dual-buffer receive unit. Decodes the register map, wires
// the frame writer to the ping buffer and (when PONG_EN) the pong buffer, and
// produces the interrupt pulse. Assumes bus reads are combinational.
module rxpp_dual_rx
    import rxpp_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int REGION_LG = 11,
    parameter bit PONG_EN   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               rx_irq
);
    localparam int IDX_W     = REGION_LG - 2;
    localparam int BUF_WORDS = (1 << IDX_W) - 1;
    localparam int REG_W     = ADDR_W - REGION_LG;
    localparam logic [REG_W-1:0]  PING_REGION = REG_W'(2);
    localparam logic [REG_W-1:0]  PONG_REGION = REG_W'(3);
    localparam logic [IDX_W-1:0]  STAT_IDX    = '1;

    logic [REG_W-1:0]  region;
    logic [IDX_W-1:0]  word_idx;
    logic              at_status;
    logic [1:0]        sel_region, sw_wr_v, done_v, ie_v, wr_en_v, commit_v;
    logic [31:0]       rd_word_v [2];

    logic              w_wr_en, w_sel, w_commit;
    logic [IDX_W-1:0]  w_idx;
    logic [WORD_W-1:0] w_word;
    logic              irq_q;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:4], bus_wdata[2:1], bus_addr[1:0]};

    // Address decode into region and word index.
    always_comb begin
        region        = bus_addr[ADDR_W-1:REGION_LG];
        word_idx      = bus_addr[REGION_LG-1:2];
        at_status     = (word_idx == STAT_IDX);
        sel_region[0] = (region == PING_REGION);
        sel_region[1] = (region == PONG_REGION) && PONG_EN;
        sw_wr_v       = {2{bus_wr && at_status}} & sel_region;
        wr_en_v       = {w_wr_en && w_sel, w_wr_en && !w_sel};
        commit_v      = {w_commit && w_sel, w_commit && !w_sel};
    end

    rxpp_frame_writer #(.IDX_W(IDX_W), .BUF_WORDS(BUF_WORDS), .PONG_EN(PONG_EN)) u_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .buf_done(done_v),
        .wr_en(w_wr_en), .wr_sel(w_sel), .wr_idx(w_idx), .wr_word(w_word), .commit(w_commit)
    );

    for (genvar b = 0; b < 2; b++) begin : g_buf
        if (b == 0 || PONG_EN) begin : g_present
            rxpp_buffer #(.IDX_W(IDX_W), .BUF_WORDS(BUF_WORDS)) u_buf (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_en_v[b]), .wr_idx(w_idx),
                .wr_word(w_word), .commit(commit_v[b]), .sw_wr(sw_wr_v[b]),
                .sw_done_keep(bus_wdata[DONE_BIT]), .sw_ie(bus_wdata[IE_BIT]),
                .rd_idx(word_idx), .rd_word(rd_word_v[b]), .done(done_v[b]), .ie(ie_v[b])
            );
        end else begin : g_absent
            assign rd_word_v[b] = '0;
            assign done_v[b]    = 1'b0;
            assign ie_v[b]      = 1'b0;
        end
    end

    // Read mux: status word, data word, or zero outside both regions.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < 2; b++) begin
            if (sel_region[b]) begin
                if (at_status) begin
                    bus_rdata[DONE_BIT] = done_v[b];
                    bus_rdata[IE_BIT]   = ie_v[b];
                end else begin
                    bus_rdata = rd_word_v[b];
                end
            end
        end
    end

    // Interrupt pulse on a completion in a buffer with its enable set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= w_commit && ie_v[w_sel];
    end
    assign rx_irq = irq_q;

    // R8: every pulse matches a rising done flag whose enable was set
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (($rose(done_v[0]) && $past(ie_v[0])) || ($rose(done_v[1]) && $past(ie_v[1]))));
endmodule

// File: tb/test_rxpp_dual_rx.sv
module test_rxpp_dual_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, use_single = 1'b0;
    logic [7:0]  s_data = '0;
    logic [12:0] b_addr = '0;
    logic        b_wr = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata0, rdata1, rd;
    logic        irq0, irq1, seen_irq;
    int checks = 0, errors = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    rxpp_dual_rx #(.PONG_EN(1'b1)) i_rxpp_dual_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(s_valid && !use_single), .in_data(s_data),
        .in_sof(s_sof), .in_eof(s_eof), .bus_addr(b_addr), .bus_wr(b_wr && !use_single),
        .bus_wdata(b_wdata), .bus_rdata(rdata0), .rx_irq(irq0));

    rxpp_dual_rx #(.PONG_EN(1'b0)) i_rxpp_single (
        .clk(clk), .rst_n(rst_n), .in_valid(s_valid && use_single), .in_data(s_data),
        .in_sof(s_sof), .in_eof(s_eof), .bus_addr(b_addr), .bus_wr(b_wr && use_single),
        .bus_wdata(b_wdata), .bus_rdata(rdata1), .rx_irq(irq1));

    localparam logic [12:0] PING = 13'h1000, PONG = 13'h1800;
    localparam logic [12:0] PING_ST = 13'h17FC, PONG_ST = 13'h1FFC;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int seed, int len, int w);
        logic [31:0] r = '0;
        for (int j = 0; j < 4; j++)
            if (4*w + j < len) r[8*j +: 8] = 8'((seed + 4*w + j) & 8'hFF);
        return r;
    endfunction

    task automatic bus_read(logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        b_addr = a;
        #0.5;
        d = use_single ? rdata1 : rdata0;
    endtask

    task automatic bus_write(logic [12:0] a, logic [31:0] d);
        @(negedge clk);
        b_addr = a; b_wdata = d; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic drive_byte(logic [7:0] d, logic sof, logic eof);
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof;
    endtask

    // Sends a frame; records the interrupt seen in the cycle after the end byte.
    task automatic send_frame(int seed, int len);
        for (int k = 0; k < len; k++)
            drive_byte(8'((seed + k) & 8'hFF), k == 0, k == len - 1);
        @(negedge clk);
        s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
        seen_irq = use_single ? irq1 : irq0;
        @(negedge clk);
        check("R8 irq single cycle", {31'b0, use_single ? irq1 : irq0}, 32'd0);
    endtask

    task automatic check_frame(string req, logic [12:0] base, int seed, int len);
        for (int w = 0; w < (len + 3) / 4; w++) begin
            bus_read(base + 13'(4*w), rd);
            check(req, rd, exp_word(seed, len, w));
        end
    endtask

    task automatic t_reset;
        bus_read(PING_ST, rd); check("R1 ping status", rd, 32'h0);
        bus_read(PONG_ST, rd); check("R1 pong status", rd, 32'h0);
        check("R1 irq low", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_basic;
        bus_write(PING_ST, 32'h8);
        bus_read(PING_ST, rd); check("R7 ie set", rd, 32'h8);
        send_frame(8'h10, 7);
        check("R8 irq pulse", {31'b0, seen_irq}, 32'h1);
        bus_read(PING_ST, rd); check("R4 ping done", rd, 32'h9);
        check_frame("R3 ping packing", PING, 8'h10, 7);
    endtask

    task automatic t_alternate;
        send_frame(8'h40, 5);
        check("R8 no irq when disabled", {31'b0, seen_irq}, 32'h0);
        bus_read(PONG_ST, rd); check("R5 pong done", rd, 32'h1);
        check_frame("R5 pong data", PONG, 8'h40, 5);
        bus_write(PING_ST, 32'h8);
        bus_read(PING_ST, rd); check("R7 flush ping", rd, 32'h8);
        send_frame(8'h70, 4);
        bus_read(PING_ST, rd); check("R5 back to ping", rd, 32'h9);
        check_frame("R5 ping data", PING, 8'h70, 4);
    endtask

    task automatic t_drop;
        send_frame(8'hA0, 8);
        bus_read(PONG_ST, rd); check("R6 pong still held", rd, 32'h1);
        check_frame("R6 pong unchanged", PONG, 8'h40, 5);
        bus_write(PING_ST, 32'h1);
        bus_read(PING_ST, rd); check("R7 write 1 keeps done", rd, 32'h1);
        bus_write(PONG_ST, 32'h0);
        bus_write(PONG_ST, 32'h9);
        bus_read(PONG_ST, rd); check("R7 cannot set done", rd, 32'h8);
        bus_write(PONG_ST, 32'h0);
        send_frame(8'hC0, 6);
        bus_read(PONG_ST, rd); check("R6 retry same buffer", rd, 32'h1);
        check_frame("R6 retried data", PONG, 8'hC0, 6);
        bus_read(PING_ST, rd); check("R6 ping untouched", rd, 32'h1);
    endtask

    task automatic t_map;
        bus_read(13'h0000, rd); check("R2 low region zero", rd, 32'h0);
        bus_read(13'h0804, rd); check("R2 unmapped zero", rd, 32'h0);
    endtask

    task automatic t_restart;
        bus_write(PING_ST, 32'h0);
        for (int k = 0; k < 3; k++) drive_byte(8'hEE, 1'b0, k == 2);
        @(negedge clk); s_valid = 1'b0; s_eof = 1'b0;
        bus_read(PING_ST, rd); check("R11 stray bytes ignored", rd, 32'h0);
        bus_read(PING, rd); check("R11 data kept", rd, exp_word(8'h70, 4, 0));
        for (int k = 0; k < 6; k++) drive_byte(8'h20 + 8'(k), k == 0, 1'b0);
        send_frame(8'h50, 5);
        bus_read(PING_ST, rd); check("R11 restarted frame done", rd, 32'h1);
        check_frame("R11 restart data", PING, 8'h50, 5);
    endtask

    task automatic t_trunc;
        bus_write(PONG_ST, 32'h0);
        send_frame(8'h33, 2050);
        bus_read(PONG_ST, rd); check("R9 status intact", rd, 32'h1);
        bus_read(PONG, rd); check("R9 first word", rd, exp_word(8'h33, 2050, 0));
        bus_read(PONG + 13'(4*510), rd); check("R9 last word", rd, exp_word(8'h33, 2050, 510));
    endtask

    task automatic t_single;
        use_single = 1'b1;
        bus_write(PING_ST, 32'h8);
        send_frame(8'h11, 5);
        check("R8 single irq", {31'b0, seen_irq}, 32'h1);
        bus_read(PING_ST, rd); check("R10 ping done", rd, 32'h9);
        bus_write(PING_ST, 32'h8);
        send_frame(8'h22, 6);
        bus_read(PING_ST, rd); check("R10 second frame ping", rd, 32'h9);
        check_frame("R10 ping data", PING, 8'h22, 6);
        send_frame(8'h99, 3);
        check_frame("R6 single drop", PING, 8'h22, 6);
        bus_read(PONG_ST, rd); check("R10 pong status zero", rd, 32'h0);
        bus_read(PONG, rd); check("R10 pong data zero", rd, 32'h0);
        use_single = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_alternate();
        t_drop();
        t_map();
        t_restart();
        t_trunc();
        t_single();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule